// File: doc/BRIEF.md
# Interrupt Controller Programming Port

This block is the byte-wide, two-address register port that sits in front of one eight-line interrupt controller core. Software writes byte words to address 0 or address 1. The port sorts each word into one of three kinds: a start-of-setup word, a read/poll control word or a priority command word. A short sequencer walks through the setup words that follow, and the port keeps the resulting mode fields and mask register. Priority commands are passed to the core as one-cycle strobes that carry the written command code and line number.

The core owns the request and in-service registers and the priority resolution. It feeds the port its request and in-service bytes and a combinational winner (a valid flag and a line number). The port returns these bytes on reads. When a poll is armed, the next read returns the current winner and tells the core to clear that line. With the default configuration, read data is registered and appears one cycle after the read strobe.

Top module: `pic_prog_port`

## Requirements
- R1: After reset, the mask, vector base, nested, auto-EOI, rotate-on-auto-EOI, in-service-select, poll and special-mask outputs are all 0, and no strobe (core_init, op_valid, rd_valid, poll_clr) is high.
- R2: A write to address 0 with bit 4 set pulses core_init for exactly the next cycle. It clears the mask, vector base, nested, auto-EOI, rotate, select, poll and special-mask fields, and it starts the setup sequence whatever state the sequencer is in.
- R3: The first address-1 write after the start word sets vec_base to that byte with bits 2..0 forced to 0.
- R4: The start word's bit 0 records whether a mode word follows. The second address-1 write ends setup if bit 0 was 0. Otherwise a third address-1 write is taken as the mode word, where bit 4 sets nested_mode and bit 1 sets auto_eoi.
- R5: Outside setup, an address-1 write loads the mask. Address-1 writes that are consumed by setup leave the mask unchanged.
- R6: An address-0 write with bit 4 = 0 and bit 3 = 1 is a control word. Bit 2 = 1 arms poll. When bit 1 = 1, bit 0 sets sel_isr (1 = in-service, 0 = request). When bit 6 = 1, bit 5 sets spec_mask. Cleared bits 1 and 6 leave their fields unchanged.
- R7: An address-0 write with bits 4 and 3 both 0 and command code bits 7..5 equal to 1, 3, 5, 6 or 7 pulses op_valid for the next cycle. op_code carries the code and op_line carries bits 2..0.
- R8: Command codes 0 and 4 copy bit 7 to rot_aeoi without a strobe. Code 2 changes nothing.
- R9: A read with no poll armed returns data on rdata, with rd_valid, in the following cycle. At address 0 it returns the in-service byte if sel_isr is set and the request byte otherwise. At address 1 it returns the mask.
- R10: A read while poll is armed, at either address, returns {5'b0, winner_id} and pulses poll_clr with poll_line = winner_id if winner_valid is set. Otherwise it returns 8'h07 with no poll_clr. Poll is disarmed afterwards in both cases.
- R11: Bits 1 and 3 of the start word have no effect. A start word with them set produces the same outputs as one with them clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 1 | Port address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rd_valid | output | 1 | rdata valid |
| irr_in | input | 8 | Core request register |
| isr_in | input | 8 | Core in-service register |
| winner_valid | input | 1 | Core has a winning line |
| winner_id | input | 3 | Winning line number |
| core_init | output | 1 | Core reset / output-drop pulse |
| mask_o | output | 8 | Mask register |
| vec_base | output | 8 | Vector base, low bits zero |
| nested_mode | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| rot_aeoi | output | 1 | Rotate on automatic EOI |
| sel_isr | output | 1 | Address-0 read selects in-service |
| poll_pending | output | 1 | Poll armed |
| spec_mask | output | 1 | Special mask mode |
| op_valid | output | 1 | Priority command strobe |
| op_code | output | 3 | Command code of the strobe |
| op_line | output | 3 | Line field of the strobe |
| poll_clr | output | 1 | Clear winning line strobe |
| poll_line | output | 3 | Line to clear |

## Verification
Every write takes effect at the clock edge that samples it. Mode fields and the mask can be seen one cycle later, and core_init and op_valid are high for exactly that one cycle. Read results (rdata, rd_valid, poll_clr, poll_line) are also due one cycle after the read strobe. The bench drives each access on a falling edge, removes it at the next falling edge and compares all outputs there, in the middle of the single cycle in which the strobes are high. The winner, request and in-service inputs are held with the read strobe, so the sampled values are the ones the model used.

// File: rtl/pic_pp_pkg.sv
package pic_pp_pkg;
   localparam int unsigned BIT_START   = 4;
   localparam int unsigned BIT_CTRL    = 3;
   localparam int unsigned BIT_POLL    = 2;
   localparam int unsigned BIT_SEL_EN  = 1;
   localparam int unsigned BIT_SEL_VAL = 0;
   localparam int unsigned BIT_SMM_EN  = 6;
   localparam int unsigned BIT_SMM_VAL = 5;
   localparam int unsigned BIT_NEED4   = 0;
   localparam int unsigned BIT_NESTED  = 4;
   localparam int unsigned BIT_AEOI    = 1;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_BASE = 2'd1,
      SEQ_CASC = 2'd2,
      SEQ_MODE = 2'd3
   } seq_state_e;

   typedef enum logic [2:0] {
      CMD_ROT_CLR  = 3'd0,
      CMD_EOI_NS   = 3'd1,
      CMD_NOP      = 3'd2,
      CMD_EOI_SP   = 3'd3,
      CMD_ROT_SET  = 3'd4,
      CMD_EOI_NSR  = 3'd5,
      CMD_SET_PRIO = 3'd6,
      CMD_EOI_SPR  = 3'd7
   } cmd_code_e;
endpackage

// File: rtl/pic_pp_init_seq.sv
module pic_pp_init_seq
   import pic_pp_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LINE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              core_init,
   output logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] vec_q,
   output logic              nested_q,
   output logic              aeoi_q
);
   seq_state_e state_q;
   logic       need4_q;
   logic       start_wr;
   logic       data_wr;

   assign start_wr = wr_en && !addr && wdata[BIT_START];
   assign data_wr  = wr_en && addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= SEQ_IDLE;
         need4_q   <= 1'b0;
         mask_q    <= '0;
         vec_q     <= '0;
         nested_q  <= 1'b0;
         aeoi_q    <= 1'b0;
         core_init <= 1'b0;
      end else begin
         core_init <= 1'b0;
         if (start_wr) begin
            core_init <= 1'b1;
            state_q   <= SEQ_BASE;
            need4_q   <= wdata[BIT_NEED4];
            mask_q    <= '0;
            vec_q     <= '0;
            nested_q  <= 1'b0;
            aeoi_q    <= 1'b0;
         end else if (data_wr) begin
            unique case (state_q)
               SEQ_IDLE: mask_q <= wdata;
               SEQ_BASE: begin
                  vec_q   <= {wdata[DATA_W-1:LINE_W], {LINE_W{1'b0}}};
                  state_q <= SEQ_CASC;
               end
               SEQ_CASC: state_q <= need4_q ? SEQ_MODE : SEQ_IDLE;
               SEQ_MODE: begin
                  nested_q <= wdata[BIT_NESTED];
                  aeoi_q   <= wdata[BIT_AEOI];
                  state_q  <= SEQ_IDLE;
               end
               default: state_q <= SEQ_IDLE;
            endcase
         end
      end
   end

   p_mode_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_MODE) |-> need4_q);
   p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mask_q));
   p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
      core_init |-> (mask_q == '0 && vec_q == '0 && !nested_q && !aeoi_q));
   p_start_enters_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_wr |=> (state_q == SEQ_BASE));
endmodule

// File: rtl/pic_pp_cmd_decode.sv
module pic_pp_cmd_decode
   import pic_pp_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LINE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              poll_take,
   output logic              rot_q,
   output logic              sel_q,
   output logic              poll_q,
   output logic              smm_q,
   output logic              op_valid,
   output logic [2:0]        op_code,
   output logic [LINE_W-1:0] op_line
);
   logic      start_wr, ctrl_wr, cmd_wr;
   cmd_code_e code;

   assign start_wr = wr_en && !addr && wdata[BIT_START];
   assign ctrl_wr  = wr_en && !addr && !wdata[BIT_START] && wdata[BIT_CTRL];
   assign cmd_wr   = wr_en && !addr && !wdata[BIT_START] && !wdata[BIT_CTRL];
   assign code     = cmd_code_e'(wdata[DATA_W-1 -: 3]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rot_q    <= 1'b0;
         sel_q    <= 1'b0;
         poll_q   <= 1'b0;
         smm_q    <= 1'b0;
         op_valid <= 1'b0;
         op_code  <= '0;
         op_line  <= '0;
      end else begin
         op_valid <= 1'b0;
         if (start_wr) begin
            rot_q  <= 1'b0;
            sel_q  <= 1'b0;
            poll_q <= 1'b0;
            smm_q  <= 1'b0;
         end else begin
            if (poll_take) poll_q <= 1'b0;
            if (ctrl_wr) begin
               if (wdata[BIT_POLL])   poll_q <= 1'b1;
               if (wdata[BIT_SEL_EN]) sel_q  <= wdata[BIT_SEL_VAL];
               if (wdata[BIT_SMM_EN]) smm_q  <= wdata[BIT_SMM_VAL];
            end
            if (cmd_wr) begin
               unique case (code)
                  CMD_ROT_CLR, CMD_ROT_SET: rot_q <= wdata[DATA_W-1];
                  CMD_EOI_NS, CMD_EOI_SP, CMD_EOI_NSR,
                  CMD_SET_PRIO, CMD_EOI_SPR: begin
                     op_valid <= 1'b1;
                     op_code  <= code;
                     op_line  <= wdata[LINE_W-1:0];
                  end
                  default: ;
               endcase
            end
         end
      end
   end

   p_op_code_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid |-> (op_code != 3'd0 && op_code != 3'd2 && op_code != 3'd4));
   p_poll_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_take && !wr_en) |=> !poll_q);
   p_ctrl_no_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> !op_valid);
endmodule

// File: rtl/pic_pp_read_port.sv
module pic_pp_read_port #(
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned LINE_W          = 3,
   parameter bit          READ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              addr,
   input  logic [DATA_W-1:0] irr_in,
   input  logic [DATA_W-1:0] isr_in,
   input  logic [DATA_W-1:0] mask_q,
   input  logic              sel_q,
   input  logic              poll_q,
   input  logic              winner_valid,
   input  logic [LINE_W-1:0] winner_id,
   output logic              poll_take,
   output logic [DATA_W-1:0] rdata,
   output logic              rd_valid,
   output logic              poll_clr,
   output logic [LINE_W-1:0] poll_line
);
   localparam logic [DATA_W-1:0] NO_WINNER = DATA_W'((1 << LINE_W) - 1);

   logic [DATA_W-1:0] rd_mux;
   logic              clr_now;

   assign poll_take = rd_en && poll_q;
   assign clr_now   = poll_take && winner_valid;

   always_comb begin
      if (poll_q)
         rd_mux = winner_valid ? DATA_W'(winner_id) : NO_WINNER;
      else if (addr)
         rd_mux = mask_q;
      else
         rd_mux = sel_q ? isr_in : irr_in;
   end

   generate
      if (READ_REGISTERED) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rdata     <= '0;
               rd_valid  <= 1'b0;
               poll_clr  <= 1'b0;
               poll_line <= '0;
            end else begin
               rd_valid <= rd_en;
               poll_clr <= clr_now;
               if (rd_en) rdata <= rd_mux;
               if (clr_now) poll_line <= winner_id;
            end
         end
         p_rdval_r9: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en |=> rd_valid);
         p_poll_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
            poll_clr |-> rd_valid);
      end else begin : g_comb
         assign rdata     = rd_en ? rd_mux : '0;
         assign rd_valid  = rd_en;
         assign poll_clr  = clr_now;
         assign poll_line = winner_id;
      end
   endgenerate
endmodule

// File: rtl/pic_prog_port.sv
module pic_prog_port #(
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned NUM_LINES       = 8,
   parameter bit          READ_REGISTERED = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic                          rd_en,
   input  logic                          addr,
   input  logic [DATA_W-1:0]             wdata,
   output logic [DATA_W-1:0]             rdata,
   output logic                          rd_valid,
   input  logic [DATA_W-1:0]             irr_in,
   input  logic [DATA_W-1:0]             isr_in,
   input  logic                          winner_valid,
   input  logic [$clog2(NUM_LINES)-1:0]  winner_id,
   output logic                          core_init,
   output logic [DATA_W-1:0]             mask_o,
   output logic [DATA_W-1:0]             vec_base,
   output logic                          nested_mode,
   output logic                          auto_eoi,
   output logic                          rot_aeoi,
   output logic                          sel_isr,
   output logic                          poll_pending,
   output logic                          spec_mask,
   output logic                          op_valid,
   output logic [2:0]                    op_code,
   output logic [$clog2(NUM_LINES)-1:0]  op_line,
   output logic                          poll_clr,
   output logic [$clog2(NUM_LINES)-1:0]  poll_line
);
   localparam int unsigned LINE_W = $clog2(NUM_LINES);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("pic_prog_port: command bit positions need DATA_W == 8");
      end
      if (NUM_LINES != 8) begin : g_bad_lines
         $error("pic_prog_port: line fields are three bits, NUM_LINES must be 8");
      end
   endgenerate

   logic poll_take;

   pic_pp_init_seq #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_init (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .core_init (core_init),
      .mask_q    (mask_o),
      .vec_q     (vec_base),
      .nested_q  (nested_mode),
      .aeoi_q    (auto_eoi)
   );

   pic_pp_cmd_decode #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_cmd (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .poll_take (poll_take),
      .rot_q     (rot_aeoi),
      .sel_q     (sel_isr),
      .poll_q    (poll_pending),
      .smm_q     (spec_mask),
      .op_valid  (op_valid),
      .op_code   (op_code),
      .op_line   (op_line)
   );

   pic_pp_read_port #(
      .DATA_W          (DATA_W),
      .LINE_W          (LINE_W),
      .READ_REGISTERED (READ_REGISTERED)
   ) u_rd (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_en        (rd_en),
      .addr         (addr),
      .irr_in       (irr_in),
      .isr_in       (isr_in),
      .mask_q       (mask_o),
      .sel_q        (sel_isr),
      .poll_q       (poll_pending),
      .winner_valid (winner_valid),
      .winner_id    (winner_id),
      .poll_take    (poll_take),
      .rdata        (rdata),
      .rd_valid     (rd_valid),
      .poll_clr     (poll_clr),
      .poll_line    (poll_line)
   );

   p_init_drops_poll_r2: assert property (@(posedge clk) disable iff (!rst_n)
      core_init |-> (!poll_pending && !sel_isr && !spec_mask && !rot_aeoi));
   p_strobes_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      core_init |-> !op_valid);
endmodule

// File: tb/pic_prog_port_tb.sv
module pic_prog_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
   logic [7:0] wdata = '0, irr_in = '0, isr_in = '0;
   logic       winner_valid = 1'b0;
   logic [2:0] winner_id = '0;
   logic [7:0] rdata, mask_o, vec_base;
   logic       rd_valid, core_init, nested_mode, auto_eoi, rot_aeoi;
   logic       sel_isr, poll_pending, spec_mask, op_valid, poll_clr;
   logic [2:0] op_code, op_line, poll_line;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pic_prog_port u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .irr_in(irr_in),
      .isr_in(isr_in), .winner_valid(winner_valid), .winner_id(winner_id),
      .core_init(core_init), .mask_o(mask_o), .vec_base(vec_base),
      .nested_mode(nested_mode), .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi),
      .sel_isr(sel_isr), .poll_pending(poll_pending), .spec_mask(spec_mask),
      .op_valid(op_valid), .op_code(op_code), .op_line(op_line),
      .poll_clr(poll_clr), .poll_line(poll_line)
   );

   // reference model state
   logic [7:0] m_mask, m_vec, e_rd;
   logic       m_nest, m_aeoi, m_rot, m_sel, m_poll, m_smm, m_need4;
   int         m_st;
   logic       e_init, e_opv, e_rdv, e_pclr;
   logic [2:0] e_opc, e_opl, e_pline;

   task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic void model_reset();
      m_mask = '0; m_vec = '0; m_nest = 0; m_aeoi = 0; m_rot = 0; m_sel = 0;
      m_poll = 0; m_smm = 0; m_need4 = 0; m_st = 0;
   endfunction

   function automatic void model_write(logic a, logic [7:0] d);
      e_init = 0; e_opv = 0; e_rdv = 0; e_pclr = 0;
      if (!a && d[4]) begin
         model_reset();
         e_init = 1; m_st = 1; m_need4 = d[0];
      end else if (!a && d[3]) begin
         if (d[2]) m_poll = 1;
         if (d[1]) m_sel = d[0];
         if (d[6]) m_smm = d[5];
      end else if (!a) begin
         case (d[7:5])
            3'd0, 3'd4: m_rot = d[7];
            3'd2: ;
            default: begin e_opv = 1; e_opc = d[7:5]; e_opl = d[2:0]; end
         endcase
      end else begin
         case (m_st)
            0: m_mask = d;
            1: begin m_vec = {d[7:3], 3'b000}; m_st = 2; end
            2: m_st = m_need4 ? 3 : 0;
            default: begin m_nest = d[4]; m_aeoi = d[1]; m_st = 0; end
         endcase
      end
   endfunction

   function automatic void model_read(logic a);
      e_init = 0; e_opv = 0; e_rdv = 1; e_pclr = 0;
      if (m_poll) begin
         e_rd = winner_valid ? {5'b0, winner_id} : 8'h07;
         e_pclr = winner_valid; e_pline = winner_id;
         m_poll = 0;
      end else if (a) e_rd = m_mask;
      else e_rd = m_sel ? isr_in : irr_in;
   endfunction

   task automatic check_state();
      chk("R5", "mask", mask_o, m_mask);
      chk("R3", "vec_base", vec_base, m_vec);
      chk("R4", "nested", {7'b0, nested_mode}, {7'b0, m_nest});
      chk("R4", "auto_eoi", {7'b0, auto_eoi}, {7'b0, m_aeoi});
      chk("R8", "rot_aeoi", {7'b0, rot_aeoi}, {7'b0, m_rot});
      chk("R6", "sel_isr", {7'b0, sel_isr}, {7'b0, m_sel});
      chk("R6", "spec_mask", {7'b0, spec_mask}, {7'b0, m_smm});
      chk("R10", "poll_pending", {7'b0, poll_pending}, {7'b0, m_poll});
      chk("R2", "core_init", {7'b0, core_init}, {7'b0, e_init});
      chk("R7", "op_valid", {7'b0, op_valid}, {7'b0, e_opv});
      if (e_opv) begin
         chk("R7", "op_code", {5'b0, op_code}, {5'b0, e_opc});
         chk("R7", "op_line", {5'b0, op_line}, {5'b0, e_opl});
      end
      chk("R9", "rd_valid", {7'b0, rd_valid}, {7'b0, e_rdv});
      chk("R10", "poll_clr", {7'b0, poll_clr}, {7'b0, e_pclr});
      if (e_pclr) chk("R10", "poll_line", {5'b0, poll_line}, {5'b0, e_pline});
      if (e_rdv) chk("R9", "rdata", rdata, e_rd);
   endtask

   task automatic do_wr(logic a, logic [7:0] d);
      wr_en = 1; addr = a; wdata = d;
      model_write(a, d);
      @(negedge clk);
      wr_en = 0;
      check_state();
   endtask

   task automatic do_rd(logic a, logic [7:0] irr, logic [7:0] isr, logic wv, logic [2:0] wid);
      rd_en = 1; addr = a; irr_in = irr; isr_in = isr; winner_valid = wv; winner_id = wid;
      model_read(a);
      @(negedge clk);
      rd_en = 0;
      check_state();
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] snap_a [0:3];
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      model_reset();
      e_init = 0; e_opv = 0; e_rdv = 0; e_pclr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      check_state();

      // R2/R3/R4: setup with mode word
      do_wr(0, 8'h11);
      do_wr(1, 8'h4F);             // R3 vector base low bits dropped -> 48
      do_wr(1, 8'h04);
      do_wr(1, 8'h12);             // R4 nested + auto-EOI
      do_wr(1, 8'hA5);             // R5 mask load
      // R4: setup without mode word, third address-1 write is the mask
      do_wr(0, 8'h10);
      do_wr(1, 8'h20);
      do_wr(1, 8'hFF);             // R5 consumed, mask stays 0
      do_wr(1, 8'h3C);
      // R11: ignored start-word bits
      do_wr(0, 8'h11); do_wr(1, 8'h28); do_wr(1, 8'h00); do_wr(1, 8'h02);
      snap_a[0] = mask_o; snap_a[1] = vec_base; snap_a[2] = {6'b0, nested_mode, auto_eoi};
      do_wr(0, 8'h1B); do_wr(1, 8'h28); do_wr(1, 8'h00); do_wr(1, 8'h02);
      chk("R11", "vec same", vec_base, snap_a[1]);
      chk("R11", "modes same", {6'b0, nested_mode, auto_eoi}, snap_a[2]);
      chk("R11", "mask same", mask_o, snap_a[0]);
      // R6 control words and R9 reads
      do_wr(1, 8'h5A);
      do_wr(0, 8'h0B);
      do_rd(0, 8'h11, 8'h22, 0, 0);
      do_wr(0, 8'h08);             // select unchanged
      do_rd(0, 8'h33, 8'h44, 0, 0);
      do_wr(0, 8'h0A);
      do_rd(0, 8'h55, 8'h66, 0, 0);
      do_rd(1, 8'h00, 8'h00, 0, 0);
      do_wr(0, 8'h68); do_wr(0, 8'h28); do_wr(0, 8'h48);
      // R10 poll with and without winner
      do_wr(0, 8'h0C);
      do_rd(1, 8'h00, 8'h00, 1, 3'd5);
      do_rd(1, 8'h00, 8'h00, 1, 3'd6);
      do_wr(0, 8'h0C);
      do_rd(0, 8'hFF, 8'hFF, 0, 3'd2);
      // R7/R8 every command code
      for (int c = 0; c < 8; c++) do_wr(0, 8'((c << 5) | 3));
      do_wr(0, 8'h80); do_wr(0, 8'h00);

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         int k;
         logic [7:0] d;
         k = $urandom_range(0, 9);
         d = 8'($urandom);
         if (k < 3) do_wr(1, d);
         else if (k == 3) do_wr(0, d | 8'h10);
         else if (k < 7) do_wr(0, d & 8'hEF);
         else do_rd(1'($urandom), 8'($urandom), 8'($urandom), 1'($urandom), 3'($urandom));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule